// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block decides whether a twisted-pair link is usable. It watches a one-cycle strobe that marks a received link test pulse, a level that marks receive activity, and a one-cycle tick that arrives once per millisecond. From these it keeps a link-good bit for a status register. It also drives the inverse, a link-fail level, which the transmit and receive paths use as a block signal.

While failed, the monitor brings the link up only after a run of consecutive link pulses. Each pulse in the run must follow the previous one, or the reset, by at least a minimum and at most a maximum number of ticks. A pulse outside that window starts a new run. Receive activity restores the link at once. While passing, any link pulse or any receive activity restarts a silence timer. When the timer runs out, the link drops back to fail.

All limits are parameters counted in ticks. Simulation can therefore use short values, and silicon uses the millisecond values: a 64-tick loss limit, a 4-tick minimum gap, a 64-tick maximum gap and two pulses.

Top module: `link_integrity_fsm`

## Requirements
- R1: While reset is low, and on the first cycle after it, link_up is 0 and link_fail is 1. Both the gap count and the pulse run count are zero.
- R2: link_fail is always the inverse of link_up.
- R3: While failed, a pulse is valid if its gap lies between MIN_GAP and MAX_GAP inclusive. The gap is the number of ms_tick cycles since the previous pulse or since reset. A tick in the same cycle as the pulse is not part of that gap. The valid pulse that completes PULSES_NEEDED consecutive valid pulses sets link_up on the next cycle.
- R4: While failed, a pulse with a gap below MIN_GAP clears the run count. That pulse becomes the reference for the next gap.
- R5: While failed, a pulse with a gap above MAX_GAP clears the run count. That pulse becomes the reference for the next gap.
- R6: While failed, rx_active high in a cycle sets link_up on the next cycle.
- R7: While passing, if LOSS_TICKS ticks arrive with no pulse and no receive activity, link_up clears on the cycle after the last of those ticks. A new run then starts from zero.
- R8: While passing, a pulse or rx_active high clears the silence timer, and link_up stays 1.
- R9: Cycles without ms_tick advance no timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle strobe, once per timer unit |
| pulse_seen | input | 1 | One-cycle strobe per detected link test pulse |
| rx_active | input | 1 | Receive activity present |
| link_up | output | 1 | Link-good status bit |
| link_fail | output | 1 | Link failed; blocks transmit and receive |

## Verification
Every result is due one register stage after the cycle that causes it. This holds for the rise on a qualifying pulse or receive activity, and for the fall after the last silent tick. The bench drives each stimulus for exactly one cycle, starting at a falling edge, and samples at the next falling edge. Each sample therefore sees the update made by the single rising edge in between. The gap sweeps count ticks one cycle at a time, so the expected boundary values follow directly from the tick counts.

// File: rtl/link_integrity_fsm.sv
module link_integrity_fsm #(
  parameter int LOSS_TICKS    = 64,
  parameter int MIN_GAP       = 4,
  parameter int MAX_GAP       = 64,
  parameter int PULSES_NEEDED = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic pulse_seen,
  input  logic rx_active,
  output logic link_up,
  output logic link_fail
);
  localparam int TOP = (LOSS_TICKS > MAX_GAP + 1) ? LOSS_TICKS : MAX_GAP + 1;
  localparam int CW  = $clog2(TOP + 1);
  localparam int KW  = $clog2(PULSES_NEEDED + 1);

  logic [CW-1:0] since;
  logic [KW-1:0] good;

  wire activity  = pulse_seen | rx_active;
  wire in_window = (since >= CW'(MIN_GAP)) && (since <= CW'(MAX_GAP));
  wire qualify   = pulse_seen && in_window && (good == KW'(PULSES_NEEDED - 1));
  wire expire    = ms_tick && !activity && (since == CW'(LOSS_TICKS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_up <= 1'b0;
      since   <= '0;
      good    <= '0;
    end else if (link_up) begin
      if (activity) since <= '0;
      else if (expire) begin
        link_up <= 1'b0;
        since   <= '0;
        good    <= '0;
      end else if (ms_tick) since <= since + 1'b1;
    end else begin
      if (rx_active || qualify) begin
        link_up <= 1'b1;
        since   <= '0;
        good    <= '0;
      end else if (pulse_seen) begin
        since <= '0;
        good  <= in_window ? good + 1'b1 : '0;
      end else if (ms_tick && since != CW'(MAX_GAP + 1)) since <= since + 1'b1;
    end
  end

  assign link_fail = ~link_up;

  // R6
  rx_wakes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_up && rx_active) |=> link_up);

  // R3
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_up) |-> $past(pulse_seen || rx_active));

  // R8
  hold_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_up && activity) |=> (link_up && since == '0));

  // R9
  fall_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_up) |-> $past(ms_tick));

  // R4
  early_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_up && pulse_seen && !rx_active && since < CW'(MIN_GAP)) |=> (!link_up && good == '0));

  // R7
  loss_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_up |-> (since < CW'(LOSS_TICKS) && good == '0));
endmodule

// File: tb/test_link_integrity_fsm.sv
module test_link_integrity_fsm;
  localparam int LOSS = 8;
  localparam int MINg = 2;
  localparam int MAXg = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0, pulse_seen = 1'b0, rx_active = 1'b0;
  logic link_up, link_fail;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  link_integrity_fsm #(.LOSS_TICKS(LOSS), .MIN_GAP(MINg), .MAX_GAP(MAXg), .PULSES_NEEDED(2)) i_link_integrity_fsm (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pulse_seen(pulse_seen),
    .rx_active(rx_active), .link_up(link_up), .link_fail(link_fail));

  function automatic logic valid(int g);
    return (g >= MINg) && (g <= MAXg);
  endfunction

  task automatic chk(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
    end
  endtask

  task automatic cyc(logic p, logic r, logic t);
    pulse_seen = p; rx_active = r; ms_tick = t;
    @(negedge clk);
    pulse_seen = 1'b0; rx_active = 1'b0; ms_tick = 1'b0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 1'b1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    cyc(1'b0, 1'b0, 1'b0);
    cyc(1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    chk("R1 reset link_up", link_up, 1'b0);
    chk("R1 reset link_fail", link_fail, 1'b1);

    for (int g1 = 0; g1 <= 8; g1++) begin
      for (int g2 = 0; g2 <= 8; g2++) begin
        do_reset();
        ticks(g1);
        cyc(1'b1, 1'b0, 1'b0);
        chk("R3 single pulse insufficient", link_up, 1'b0);
        ticks(g2);
        cyc(1'b1, 1'b0, 1'b0);
        chk("R3 R4 R5 pulse pair", link_up, valid(g1) && valid(g2));
        chk("R2 fail is inverse", link_fail, !(valid(g1) && valid(g2)));
        ticks(3);
        cyc(1'b1, 1'b0, 1'b0);
        chk("R4 R5 invalid pulse is new reference", link_up, valid(g2));
      end
    end

    for (int k = 0; k <= 10; k++) begin
      do_reset();
      cyc(1'b0, 1'b1, 1'b0);
      chk("R6 rx activity restores", link_up, 1'b1);
      repeat (50) cyc(1'b0, 1'b0, 1'b0);
      chk("R9 no tick no timeout", link_up, 1'b1);
      ticks(k);
      chk("R7 silence loss", link_up, k < LOSS);
      chk("R2 fail is inverse", link_fail, !(k < LOSS));
    end

    do_reset();
    cyc(1'b0, 1'b1, 1'b0);
    ticks(LOSS - 1);
    cyc(1'b1, 1'b0, 1'b0);
    ticks(LOSS - 1);
    chk("R8 pulse restarts loss timer", link_up, 1'b1);
    cyc(1'b0, 1'b1, 1'b0);
    ticks(LOSS - 1);
    chk("R8 rx restarts loss timer", link_up, 1'b1);
    ticks(1);
    chk("R7 drop after full silence", link_up, 1'b0);
    ticks(3);
    cyc(1'b1, 1'b0, 1'b0);
    chk("R7 run restarts from zero", link_up, 1'b0);
    ticks(3);
    cyc(1'b1, 1'b0, 1'b0);
    chk("R3 relink after loss", link_up, 1'b1);
    rst_n = 1'b0;
    cyc(1'b0, 1'b0, 1'b0);
    chk("R1 reset from pass", link_up, 1'b0);
    rst_n = 1'b1;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule